// File: doc/BRIEF.md
# Vectored Interrupt Controller with Processor Acknowledge

This block gathers fifteen internal event pulses and a set of external interrupt lines into one sticky status word. From that word it produces a single interrupt request for a processor. Each external line has its own sensitivity and polarity, both fixed by parameters. A line can be edge sensitive (rising or falling) or level sensitive (high or low). Software reads the status, enable and pending words through a plain register port. It clears captured events by writing ones to an acknowledge register.

When the fast option is on, the block holds 32 programmable handler addresses, one for each status bit. It drives the address of the lowest-numbered pending interrupt alongside the request. The processor reports its progress on a 2-bit acknowledge code. The block remembers which interrupt was taken, and clears that status bit when the handler returns or interrupts are re-enabled. Software does not need to write anything for this clear.

The register port has no back-pressure. A write strobe lasts one cycle and takes effect at that clock edge. A read is combinational from the read address, and no handshake is involved.

Top module: `vect_intc`

## Requirements
- R1: A one-cycle pulse on internal event input i (0 to 14) sets status bit i at the next clock edge. The bit stays set until it is cleared. The status register is read at address 0x00.
- R2: External line n appears at status bit 16+n. Bit 15 and every bit at or above 16+NUM_EXT always read 0 in the status, enable and pending registers.
- R3: An edge-sensitive line with polarity 1 captures on a rising edge, and with polarity 0 on a falling edge. A line held steady at its active level captures only once. A line already active when reset ends does not capture.
- R4: A level-sensitive line with polarity 1 sets its status bit on every cycle it is high, and with polarity 0 on every cycle it is low. The bit therefore reappears after an acknowledge while the line stays active.
- R5: The enable register (address 0x02) is written and read back. The pending register (address 0x01) equals status AND enable.
- R6: Writing the acknowledge register (address 0x03) clears each status bit whose written bit is 1. Bits written 0 are unchanged. An event captured in the same cycle wins over the clear.
- R7: The request output is 1 exactly while the pending register is nonzero.
- R8: Vector register k is written at address 0x20+k. With the fast option on, the address output carries the vector of the lowest-numbered pending bit. When nothing is pending, the address output is 0.
- R9: Acknowledge code 01 latches the number of the currently selected interrupt. The next code 10 or 11 clears that one status bit, once. Any further 10 or 11 has no effect until another 01 arrives. Code 00 does nothing.
- R10: Reset clears status, enable and all vector registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| int_evt_i | input | 15 | Internal event pulses, bit i to status bit i |
| ext_irq_i | input | NUM_EXT | External interrupt lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 6 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| ack_code_i | input | 2 | Processor acknowledge code |
| irq_o | output | 1 | Interrupt request |
| irq_addr_o | output | VEC_W | Handler address of the selected interrupt |

## Verification
Assertions check on every cycle that captured events are never lost and that a status bit only drops when a clear was applied. They also check that a requested clear takes effect unless a capture competes with it, and that the selected interrupt is always the lowest pending one. They further check that the serviced-number latch drops after a return or re-enable code. The bench scenarios show the parts a single-cycle property cannot see. These include the edge detector ignoring a held line and the level lines re-capturing after an acknowledge. They also include the latched number surviving a change of selection, and the vector registers returning to zero after a second reset.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned VIC_DW       = 32;
  localparam int unsigned VIC_AW       = 6;
  localparam int unsigned VIC_NINT     = 15;
  localparam int unsigned VIC_EXT_BASE = 16;
  localparam int unsigned VIC_NVEC     = 32;
  localparam int unsigned VIC_IDX_W    = $clog2(VIC_NVEC);

  localparam logic [VIC_AW-1:0] REG_STATUS  = 6'h00;
  localparam logic [VIC_AW-1:0] REG_PENDING = 6'h01;
  localparam logic [VIC_AW-1:0] REG_ENABLE  = 6'h02;
  localparam logic [VIC_AW-1:0] REG_ACK     = 6'h03;

  localparam logic [1:0] ACK_IDLE = 2'b00;
  localparam logic [1:0] ACK_TAKE = 2'b01;
  localparam logic [1:0] ACK_RET  = 2'b10;
  localparam logic [1:0] ACK_REEN = 2'b11;
endpackage

// File: rtl/vic_ext_cond.sv
module vic_ext_cond #(
  parameter int unsigned NUM_EXT = 16,
  parameter logic [NUM_EXT-1:0] EDGE_MASK = '1,
  parameter logic [NUM_EXT-1:0] POL_MASK  = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_i,
  output logic [NUM_EXT-1:0] hit_o
);
  for (genvar n = 0; n < NUM_EXT; n++) begin : g_line
    logic active;
    assign active = (ext_i[n] == POL_MASK[n]);
    if (EDGE_MASK[n]) begin : g_edge
      logic prev_act_q;
      // reset as "already active" so a line held active out of reset is no edge
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_act_q <= 1'b1;
        else         prev_act_q <= active;
      end
      assign hit_o[n] = active & ~prev_act_q;
      // R3: an edge hit never repeats on two consecutive cycles
      assert_edge_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o[n] |=> !hit_o[n]);
    end else begin : g_level
      assign hit_o[n] = active;
    end
  end
endmodule

// File: rtl/vic_status.sv
module vic_status
  import vic_pkg::*;
#(
  parameter int unsigned NUM_EXT = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [VIC_NINT-1:0] int_evt_i,
  input  logic [NUM_EXT-1:0]  ext_hit_i,
  input  logic [VIC_DW-1:0]   ack_clr_i,
  input  logic [VIC_DW-1:0]   svc_clr_i,
  input  logic                en_we_i,
  input  logic [VIC_DW-1:0]   en_wdata_i,
  output logic [VIC_DW-1:0]   status_o,
  output logic [VIC_DW-1:0]   enable_o,
  output logic [VIC_DW-1:0]   pending_o
);
  localparam logic [VIC_DW-1:0] IMPL_MASK =
    32'h0000_7FFF | (((32'd1 << NUM_EXT) - 32'd1) << VIC_EXT_BASE);

  logic [VIC_DW-1:0] status_q, enable_q, set_vec, clr_vec, status_d;

  always_comb begin
    set_vec = '0;
    set_vec[VIC_NINT-1:0] = int_evt_i;
    set_vec[VIC_EXT_BASE +: NUM_EXT] = ext_hit_i;
  end

  assign clr_vec  = ack_clr_i | svc_clr_i;
  assign status_d = ((status_q & ~clr_vec) | set_vec) & IMPL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_d;
      if (en_we_i) enable_q <= en_wdata_i & IMPL_MASK;
    end
  end

  assign status_o  = status_q;
  assign enable_o  = enable_q;
  assign pending_o = status_q & enable_q;

  // R1: every captured event is visible in status the next cycle
  assert_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_vec) & ~status_q) == '0));
  // R1: a status bit only falls when a clear was applied
  assert_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_q) & ~$past(clr_vec) & ~status_q) == '0));
  // R6 and R9: a requested clear takes effect unless a capture competes
  assert_clear_applied_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(clr_vec) & ~$past(set_vec) & status_q) == '0));
endmodule

// File: rtl/vic_vector.sv
module vic_vector
  import vic_pkg::*;
#(
  parameter bit          FAST  = 1'b1,
  parameter int unsigned VEC_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [VIC_DW-1:0]    pending_i,
  input  logic                 vec_we_i,
  input  logic [VIC_IDX_W-1:0] vec_idx_i,
  input  logic [VEC_W-1:0]     vec_wdata_i,
  input  logic [1:0]           ack_code_i,
  output logic                 irq_o,
  output logic [VEC_W-1:0]     irq_addr_o,
  output logic [VIC_DW-1:0]    svc_clr_o
);
  logic [VIC_IDX_W-1:0] sel;
  logic                 found;

  always_comb begin
    sel = '0;
    for (int i = VIC_DW-1; i >= 0; i--) begin
      if (pending_i[i]) sel = VIC_IDX_W'(i);
    end
  end
  assign found = |pending_i;
  assign irq_o = found;

  // R8: selection is the lowest pending bit
  assert_lowest_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> (pending_i[sel] && ((pending_i & ((32'd1 << sel) - 32'd1)) == '0)));

  if (FAST) begin : g_fast
    logic [VEC_W-1:0]     vec_q [VIC_NVEC];
    logic [VIC_IDX_W-1:0] svc_idx_q;
    logic                 svc_vld_q;
    logic                 code_done;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < VIC_NVEC; k++) vec_q[k] <= '0;
      end else if (vec_we_i) begin
        vec_q[vec_idx_i] <= vec_wdata_i;
      end
    end

    assign code_done = (ack_code_i == ACK_RET) || (ack_code_i == ACK_REEN);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        svc_idx_q <= '0;
        svc_vld_q <= 1'b0;
      end else if (ack_code_i == ACK_TAKE) begin
        svc_idx_q <= sel;
        svc_vld_q <= found;
      end else if (code_done) begin
        svc_vld_q <= 1'b0;
      end
    end

    assign irq_addr_o = found ? vec_q[sel] : '0;
    assign svc_clr_o  = (svc_vld_q && code_done) ? (32'd1 << svc_idx_q) : '0;

    // R9: the latched number is consumed by the first return or re-enable
    assert_svc_once_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_done && ack_code_i != ACK_TAKE) |=> !svc_vld_q);
    // R9: a take with something pending arms the clear
    assert_svc_arm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_code_i == ACK_TAKE && found) |=> svc_vld_q);
  end else begin : g_plain
    assign irq_addr_o = '0;
    assign svc_clr_o  = '0;
  end
endmodule

// File: rtl/vect_intc.sv
module vect_intc
  import vic_pkg::*;
#(
  parameter int unsigned NUM_EXT = 16,
  parameter logic [NUM_EXT-1:0] EDGE_MASK = '1,
  parameter logic [NUM_EXT-1:0] POL_MASK  = '1,
  parameter bit          FAST  = 1'b1,
  parameter int unsigned VEC_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [14:0]         int_evt_i,
  input  logic [NUM_EXT-1:0]  ext_irq_i,
  input  logic                wr_en_i,
  input  logic [5:0]          wr_addr_i,
  input  logic [31:0]         wr_data_i,
  input  logic [5:0]          rd_addr_i,
  output logic [31:0]         rd_data_o,
  input  logic [1:0]          ack_code_i,
  output logic                irq_o,
  output logic [VEC_W-1:0]    irq_addr_o
);
  logic [NUM_EXT-1:0] ext_hit;
  logic [VIC_DW-1:0]  ack_clr, svc_clr, status, enable, pending;
  logic               en_we, vec_we;

  assign en_we   = wr_en_i && (wr_addr_i == REG_ENABLE);
  assign vec_we  = wr_en_i && wr_addr_i[5];
  assign ack_clr = (wr_en_i && (wr_addr_i == REG_ACK)) ? wr_data_i : '0;

  vic_ext_cond #(
    .NUM_EXT  (NUM_EXT),
    .EDGE_MASK(EDGE_MASK),
    .POL_MASK (POL_MASK)
  ) u_ext (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ext_i (ext_irq_i),
    .hit_o (ext_hit)
  );

  vic_status #(.NUM_EXT(NUM_EXT)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .int_evt_i (int_evt_i),
    .ext_hit_i (ext_hit),
    .ack_clr_i (ack_clr),
    .svc_clr_i (svc_clr),
    .en_we_i   (en_we),
    .en_wdata_i(wr_data_i),
    .status_o  (status),
    .enable_o  (enable),
    .pending_o (pending)
  );

  vic_vector #(.FAST(FAST), .VEC_W(VEC_W)) u_vec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pending_i  (pending),
    .vec_we_i   (vec_we),
    .vec_idx_i  (wr_addr_i[4:0]),
    .vec_wdata_i(VEC_W'(wr_data_i)),
    .ack_code_i (ack_code_i),
    .irq_o      (irq_o),
    .irq_addr_o (irq_addr_o),
    .svc_clr_o  (svc_clr)
  );

  always_comb begin
    unique case (rd_addr_i)
      REG_STATUS:  rd_data_o = status;
      REG_PENDING: rd_data_o = pending;
      REG_ENABLE:  rd_data_o = enable;
      default:     rd_data_o = '0;
    endcase
  end

  // R2: the reserved position between internal and external fields never reads set
  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == REG_STATUS) |-> !rd_data_o[15]);
  // R7: a request is raised whenever the pending register reads nonzero
  assert_irq_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == REG_PENDING && rd_data_o != '0) |-> irq_o);
endmodule

// File: tb/vect_intc_bench.sv
`timescale 1ns/1ps
module vect_intc_bench;
  localparam int unsigned NE = 4;
  localparam logic [NE-1:0] IDLE = 4'b1010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] int_evt = '0;
  logic [NE-1:0] ext_irq = IDLE;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  ack_code = 2'b00;
  logic        irq;
  logic [31:0] irq_addr;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  vect_intc #(
    .NUM_EXT(NE), .EDGE_MASK(4'b0011), .POL_MASK(4'b0101), .FAST(1'b1), .VEC_W(32)
  ) u_vect_intc (
    .clk_i(clk), .rst_ni(rst_n), .int_evt_i(int_evt), .ext_irq_i(ext_irq),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ack_code_i(ack_code),
    .irq_o(irq), .irq_addr_o(irq_addr)
  );

  // evt(15) | ext(4) | expected status(32)
  localparam logic [50:0] TBL [0:6] = '{
    {15'h0001, 4'b1010, 32'h0000_0001},
    {15'h4000, 4'b1011, 32'h0001_4000},
    {15'h0000, 4'b1000, 32'h0002_0000},
    {15'h0000, 4'b1110, 32'h0004_0000},
    {15'h0000, 4'b0010, 32'h0008_0000},
    {15'h7FFF, 4'b0101, 32'h000F_7FFF},
    {15'h0A50, 4'b1010, 32'h0000_0A50}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse(input logic [14:0] v);
    @(negedge clk); int_evt = v;
    @(negedge clk); int_evt = '0;
  endtask

  task automatic code(input logic [1:0] c);
    @(negedge clk); ack_code = c;
    @(negedge clk); ack_code = 2'b00;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++; total++;
        $display("FAIL watchdog R1 actual=%0d expected=<20000 cycles", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10 reset state
    rd(6'h00, d); chk("R10 status after reset", d, 32'h0);
    rd(6'h02, d); chk("R10 enable after reset", d, 32'h0);
    chk("R7 irq after reset", {31'h0, irq}, 32'h0);
    chk("R8 addr idle", irq_addr, 32'h0);

    // table walk: R1 R2 R3 R4 capture patterns
    for (int e = 0; e < 7; e++) begin
      wr(6'h03, 32'hFFFF_FFFF);
      @(negedge clk); int_evt = TBL[e][50:36]; ext_irq = TBL[e][35:32];
      @(negedge clk); int_evt = '0; ext_irq = IDLE;
      @(negedge clk);
      rd(6'h00, d);
      chk($sformatf("R1 R2 table entry %0d", e), d, TBL[e][31:0]);
    end
    wr(6'h03, 32'hFFFF_FFFF);

    // R3: steady active edge line captures once
    @(negedge clk); ext_irq = 4'b1011;
    repeat (3) @(negedge clk);
    rd(6'h00, d); chk("R3 held rising captured", d, 32'h0001_0000);
    wr(6'h03, 32'h0001_0000);
    @(negedge clk);
    rd(6'h00, d); chk("R3 held line no recapture", d, 32'h0);
    @(negedge clk); ext_irq = IDLE;
    @(negedge clk);
    rd(6'h00, d); chk("R3 release edge ignored", d, 32'h0);

    // R4: level line re-sets after ack
    @(negedge clk); ext_irq = 4'b1110;
    wr(6'h03, 32'h0004_0000);
    rd(6'h00, d); chk("R4 level survives ack", d, 32'h0004_0000);
    @(negedge clk); ext_irq = IDLE;
    wr(6'h03, 32'h0004_0000);
    rd(6'h00, d); chk("R4 cleared once inactive", d, 32'h0);

    // R2 R5: enable mask and pending
    wr(6'h02, 32'hFFFF_FFFF);
    rd(6'h02, d); chk("R2 enable reserved bits", d, 32'h000F_7FFF);
    pulse(15'h0005);
    wr(6'h02, 32'h0000_0004);
    rd(6'h01, d); chk("R5 pending masked", d, 32'h0000_0004);
    chk("R7 irq with pending", {31'h0, irq}, 32'h1);
    wr(6'h02, 32'h0);
    chk("R7 irq without enable", {31'h0, irq}, 32'h0);

    // R6: partial ack and zero ack
    wr(6'h03, 32'h0000_0001);
    rd(6'h00, d); chk("R6 partial ack", d, 32'h0000_0004);
    wr(6'h03, 32'h0);
    rd(6'h00, d); chk("R6 zero ack no effect", d, 32'h0000_0004);
    @(negedge clk); int_evt = 15'h0004; wr_en = 1'b1; wr_addr = 6'h03; wr_data = 32'h4;
    @(negedge clk); int_evt = '0; wr_en = 1'b0;
    rd(6'h00, d); chk("R6 capture beats clear", d, 32'h0000_0004);
    wr(6'h03, 32'hFFFF_FFFF);

    // R8: vectors
    for (int k = 0; k < 32; k++) wr(6'h20 + 6'(k), 32'h8000_0000 + 32'(k) * 16);
    wr(6'h02, 32'hFFFF_FFFF);
    pulse(15'h0088);
    chk("R8 lowest vector", irq_addr, 32'h8000_0030);
    wr(6'h03, 32'h8);
    chk("R8 next vector", irq_addr, 32'h8000_0070);

    // R9: processor acknowledge codes
    pulse(15'h0008);
    code(2'b01);
    pulse(15'h0002);
    chk("R8 selection moved lower", irq_addr, 32'h8000_0010);
    code(2'b10);
    rd(6'h00, d); chk("R9 return clears latched bit", d, 32'h0000_0082);
    pulse(15'h0008);
    code(2'b11);
    rd(6'h00, d); chk("R9 second code no effect", d, 32'h0000_008A);
    code(2'b00);
    rd(6'h00, d); chk("R9 idle code no effect", d, 32'h0000_008A);
    code(2'b01);
    code(2'b11);
    rd(6'h00, d); chk("R9 reenable clears latched bit", d, 32'h0000_0088);

    // R10: second reset clears vectors too
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(6'h00, d); chk("R10 status cleared", d, 32'h0);
    wr(6'h02, 32'hFFFF_FFFF);
    pulse(15'h0008);
    chk("R10 vector cleared", irq_addr, 32'h0);
    chk("R7 irq raised", {31'h0, irq}, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule